// File: doc/BRIEF.md
# Branch Record Event Occurrence Logger

This block keeps a short circular history of retired taken branches. Between two recorded branches it measures the cycles that pass. It also counts how often each of a handful of performance-counter events fires in that time. Every event count is a narrow saturating counter. When a branch retires, the block packs these measurements into one 64-bit info word, together with the branch type and an abort flag. It stores the word in the next slot of the ring and then restarts every counter for the next interval.

A profiler reads any slot through a combinational index port. From the stored words it can tell how long the code between two branches took, and also which events were active during that stretch. Each event field sits at the slot of its physical counter index, so software that knows which event each counter was programmed for can attribute the counts. Every counter has its own logging enable. A fixed support bitmap, published on an output, says which counters can log at all.

Top module: `brl_logger`

## Requirements
- R1: Info word layout: cycle count in bits 15:0, counter k event count in bits (33+2k):(32+2k) for k = 0..3, branch type in bits 59:56, cycle-count valid in bit 60, abort flag in bit 61.
- R2: Each event count is 2 bits wide and saturates at 3; a fourth or later pulse within one interval leaves it at 3 and never wraps to 0.
- R3: Event counts cover only the interval since the previous recorded branch; an event pulse in the same cycle as the branch strobe is counted into the record being written, and the next record starts from zero.
- R4: A counter whose enable input is low, or whose bit in the support map is clear, logs 0 in its field; `log_support` equals the support map parameter, which is 4'b1011 by default (counter 2 unsupported).
- R5: The cycle count equals the number of clock cycles from the cycle after the previous branch strobe (or the first cycle after reset release) up to and including the current strobe, so back-to-back strobes record 1; it saturates at 0xFFFF.
- R6: The valid bit is 0 in the first record after reset and 1 in every later record.
- R7: Bits 31:16, 55:40 and 63:62 of every stored word read as zero.
- R8: The ring has 8 slots written in order 0,1,...,7,0,... one per branch strobe; `rd_info` shows slot `rd_idx` combinationally.
- R9: A synchronous active-high reset clears all slots, all counters, the valid state and the write pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 4 | One pulse per cycle per counter when its event fires |
| evt_log_en | input | 4 | Per-counter logging enable |
| br_retire | input | 1 | Taken-branch retire strobe |
| br_type | input | 4 | Branch type recorded with the strobe |
| br_abort | input | 1 | Transactional abort flag recorded with the strobe |
| rd_idx | input | 3 | Slot index to read |
| rd_info | output | 64 | Stored info word of slot rd_idx |
| log_support | output | 4 | Read-only map of counters able to log events |

## Verification
The branch strobe and event counting can fall in the same cycle: the last pulse of an interval arrives together with the retire strobe. A counter saturation can also meet the strobe. The bench provokes the first case by driving pulses only in the strobe cycle, which must give a count of 1 in the new record. It provokes the second by driving pulses in the strobe cycle on top of a count already at 3. For both, it reads the written slot and then the following record, and expects the following record to start from zero.

// File: rtl/brl_pkg.sv
package brl_pkg;
    localparam int WORD_W    = 64;
    localparam int CYC_W     = 16;
    localparam int EVT_W     = 2;
    localparam int EVT_LSB   = 32;
    localparam int TYPE_LSB  = 56;
    localparam int TYPE_W    = 4;
    localparam int VALID_BIT = 60;
    localparam int ABORT_BIT = 61;
    localparam int MAX_CNT   = 4;

    // Mask of the bits that may hold data for a given number of counters.
    function automatic logic [WORD_W-1:0] defined_mask(input int n_cnt);
        logic [WORD_W-1:0] m;
        m = '0;
        for (int b = 0; b < CYC_W; b++) m[b] = 1'b1;
        for (int b = 0; b < EVT_W * n_cnt; b++) m[EVT_LSB + b] = 1'b1;
        for (int b = 0; b < TYPE_W; b++) m[TYPE_LSB + b] = 1'b1;
        m[VALID_BIT] = 1'b1;
        m[ABORT_BIT] = 1'b1;
        return m;
    endfunction
endpackage

// File: rtl/brl_evt_ctr.sv
module brl_evt_ctr #(
    parameter bit SUPPORTED = 1'b1,
    parameter int CW        = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pulse,
    input  logic          en,
    input  logic          br,
    output logic [CW-1:0] rec_val
);
    localparam logic [CW-1:0] CMAX = '1;

    generate
        if (SUPPORTED) begin : g_live
            typedef struct packed {
                logic [CW-1:0] cnt;
            } st_t;

            st_t           st_d, st_q;
            logic          hit;
            logic [CW-1:0] bumped;

            always_comb begin
                hit     = pulse & en;
                bumped  = (hit && (st_q.cnt != CMAX)) ? st_q.cnt + 1'b1 : st_q.cnt;
                rec_val = en ? bumped : '0;
                st_d    = st_q;
                if (br) begin
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = bumped;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    st_q <= '0;
                end else begin
                    st_q <= st_d;
                end
            end

            // R2: a full count holds until the next branch
            assert_evt_no_wrap_R2: assert property (@(posedge clk) disable iff (rst)
                (st_q.cnt == CMAX && !br) |=> (st_q.cnt == CMAX));

            // R3: every branch restarts the interval count
            assert_evt_restart_R3: assert property (@(posedge clk) disable iff (rst)
                br |=> (st_q.cnt == '0));

            // R4: a disabled counter does not accumulate
            assert_evt_gate_R4: assert property (@(posedge clk) disable iff (rst)
                (!en && !br) |=> $stable(st_q.cnt));

            // R2: count grows by at most one per cycle
            assert_evt_step_R2: assert property (@(posedge clk) disable iff (rst)
                !br |=> (st_q.cnt == $past(st_q.cnt) || st_q.cnt == $past(st_q.cnt) + 1'b1));
        end else begin : g_none
            logic unused_inputs;
            assign unused_inputs = ^{clk, rst, pulse, en, br};
            assign rec_val       = '0;
        end
    endgenerate
endmodule

// File: rtl/brl_cyc_ctr.sv
module brl_cyc_ctr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          br,
    output logic [CW-1:0] rec_cyc,
    output logic          rec_valid
);
    localparam logic [CW-1:0] CMAX = '1;

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic          seen;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        rec_cyc   = (st_q.cyc != CMAX) ? st_q.cyc + 1'b1 : CMAX;
        rec_valid = st_q.seen;
        st_d      = st_q;
        if (br) begin
            st_d.cyc  = '0;
            st_d.seen = 1'b1;
        end else begin
            st_d.cyc  = rec_cyc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R5: the elapsed count holds at its ceiling
    assert_cyc_saturate_R5: assert property (@(posedge clk) disable iff (rst)
        (st_q.cyc == CMAX && !br) |=> (st_q.cyc == CMAX));

    // R5: a branch restarts the interval
    assert_cyc_restart_R5: assert property (@(posedge clk) disable iff (rst)
        br |=> (st_q.cyc == '0));

    // R6: once a branch is seen, later records are valid
    assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        st_q.seen |=> st_q.seen);

    // R6: the first branch arms the valid state
    assert_valid_arm_R6: assert property (@(posedge clk) disable iff (rst)
        br |=> st_q.seen);
endmodule

// File: rtl/brl_ring.sv
module brl_ring #(
    parameter int DEPTH = 8,
    parameter int W     = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [W-1:0]             wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [W-1:0]             rd_data
);
    localparam int AW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.ptr] = wr_data;
            st_d.ptr           = st_q.ptr + 1'b1;
        end
        rd_data = st_q.mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R8: one slot per strobe, in ascending order with wrap
    assert_ptr_advance_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q.ptr == $past(st_q.ptr) + 1'b1));

    // R8: no strobe leaves the ring untouched
    assert_ring_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(st_q.mem) && $stable(st_q.ptr)));

    // R8: the written slot holds the presented word
    assert_slot_written_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st_q.mem[$past(st_q.ptr)] == $past(wr_data)));
endmodule

// File: rtl/brl_logger.sv
module brl_logger
    import brl_pkg::*;
#(
    parameter int                   NUM_CNT     = 4,
    parameter logic [NUM_CNT-1:0]   SUPPORT_MAP = 4'b1011,
    parameter int                   DEPTH       = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CNT-1:0]       evt_pulse,
    input  logic [NUM_CNT-1:0]       evt_log_en,
    input  logic                     br_retire,
    input  logic [TYPE_W-1:0]        br_type,
    input  logic                     br_abort,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [WORD_W-1:0]        rd_info,
    output logic [NUM_CNT-1:0]       log_support
);
    localparam int                AW       = $clog2(DEPTH);
    localparam logic [WORD_W-1:0] DEF_MASK = defined_mask(NUM_CNT);

    logic [NUM_CNT-1:0][EVT_W-1:0] rec_evt;
    logic [CYC_W-1:0]              rec_cyc;
    logic                          rec_valid;
    logic [WORD_W-1:0]             info_d;

    genvar k;
    generate
        for (k = 0; k < NUM_CNT; k++) begin : g_cnt
            brl_evt_ctr #(
                .SUPPORTED (SUPPORT_MAP[k]),
                .CW        (EVT_W)
            ) u_evt (
                .clk     (clk),
                .rst     (rst),
                .pulse   (evt_pulse[k]),
                .en      (evt_log_en[k]),
                .br      (br_retire),
                .rec_val (rec_evt[k])
            );
        end
    endgenerate

    brl_cyc_ctr #(
        .CW (CYC_W)
    ) u_cyc (
        .clk       (clk),
        .rst       (rst),
        .br        (br_retire),
        .rec_cyc   (rec_cyc),
        .rec_valid (rec_valid)
    );

    always_comb begin
        info_d                          = '0;
        info_d[CYC_W-1:0]               = rec_cyc;
        for (int i = 0; i < NUM_CNT; i++) begin
            info_d[EVT_LSB + EVT_W*i +: EVT_W] = rec_evt[i];
        end
        info_d[TYPE_LSB +: TYPE_W]      = br_type;
        info_d[VALID_BIT]               = rec_valid;
        info_d[ABORT_BIT]               = br_abort;
    end

    brl_ring #(
        .DEPTH (DEPTH),
        .W     (WORD_W)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (br_retire),
        .wr_data (info_d),
        .rd_idx  (rd_idx[AW-1:0]),
        .rd_data (rd_info)
    );

    assign log_support = SUPPORT_MAP;

    initial begin
        assert_cnt_limit_R4: assert (NUM_CNT <= MAX_CNT && (1 << AW) == DEPTH);
    end

    // R7: undefined positions of any stored word stay zero
    assert_undef_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_info & ~DEF_MASK) == '0);

    // R4: unsupported counters never show a nonzero field
    assert_unsup_zero_R4: assert property (@(posedge clk) disable iff (rst)
        ((rd_info[EVT_LSB +: EVT_W*NUM_CNT] & ~{NUM_CNT{2'b00}}) &
         ~{SUPPORT_MAP[3], SUPPORT_MAP[3], SUPPORT_MAP[2], SUPPORT_MAP[2],
           SUPPORT_MAP[1], SUPPORT_MAP[1], SUPPORT_MAP[0], SUPPORT_MAP[0]}) == '0);
endmodule

// File: tb/sim_brl_logger.sv
module sim_brl_logger;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  evt_pulse = '0;
    logic [3:0]  evt_log_en = '0;
    logic        br_retire = 1'b0;
    logic [3:0]  br_type = '0;
    logic        br_abort = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [63:0] rd_info;
    logic [3:0]  log_support;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    brl_logger u0 (
        .clk         (clk),
        .rst         (rst),
        .evt_pulse   (evt_pulse),
        .evt_log_en  (evt_log_en),
        .br_retire   (br_retire),
        .br_type     (br_type),
        .br_abort    (br_abort),
        .rd_idx      (rd_idx),
        .rd_info     (rd_info),
        .log_support (log_support)
    );

    typedef struct packed {
        logic [3:0]  en;
        logic [3:0]  msk;
        logic [3:0]  bmsk;
        logic [7:0]  p;
        logic [7:0]  idle;
        logic [3:0]  typ;
        logic        ab;
        logic        vld;
        logic [15:0] ecyc;
        logic [7:0]  eevt;
    } vec_t;

    // Event field byte: {c3,c2,c1,c0}, 2 bits each; counter 2 unsupported.
    localparam vec_t VECS [9] = '{
        '{4'hF, 4'hF, 4'h0, 8'd1, 8'd0, 4'd3, 1'b0, 1'b0, 16'd2, 8'h45},
        '{4'hF, 4'h1, 4'h0, 8'd5, 8'd2, 4'd5, 1'b1, 1'b1, 16'd8, 8'h03},
        '{4'hF, 4'h0, 4'hF, 8'd0, 8'd0, 4'd1, 1'b0, 1'b1, 16'd1, 8'h45},
        '{4'h5, 4'hF, 4'h0, 8'd2, 8'd0, 4'd2, 1'b0, 1'b1, 16'd3, 8'h02},
        '{4'hF, 4'h8, 4'h8, 8'd2, 8'd3, 4'hF, 1'b1, 1'b1, 16'd6, 8'hC0},
        '{4'hF, 4'h2, 4'h0, 8'd3, 8'd0, 4'd0, 1'b0, 1'b1, 16'd4, 8'h0C},
        '{4'hF, 4'hB, 4'h1, 8'd1, 8'd1, 4'd7, 1'b0, 1'b1, 16'd3, 8'h46},
        '{4'hF, 4'h0, 4'h0, 8'd0, 8'd0, 4'd9, 1'b0, 1'b1, 16'd1, 8'h00},
        '{4'hF, 4'h1, 4'h0, 8'd4, 8'd0, 4'd4, 1'b0, 1'b1, 16'd5, 8'h03}
    };

    function automatic logic [63:0] mk(input logic ab, input logic vld, input logic [3:0] t,
                                       input logic [7:0] ev, input logic [15:0] cy);
        return {2'b00, ab, vld, t, 16'h0000, ev, 16'h0000, cy};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic [3:0] pl, input logic b, input logic [3:0] t, input logic a);
        evt_pulse = pl;
        br_retire = b;
        br_type   = t;
        br_abort  = a;
        @(negedge clk);
        evt_pulse = '0;
        br_retire = 1'b0;
    endtask

    task automatic read_slot(input int s, output logic [63:0] w);
        rd_idx = s[2:0];
        #1;
        w = rd_info;
    endtask

    task automatic run_vec(input vec_t v);
        evt_log_en = v.en;
        for (int c = 0; c < v.p; c++) tick(v.msk, 1'b0, 4'd0, 1'b0);
        for (int c = 0; c < v.idle; c++) tick(4'h0, 1'b0, 4'd0, 1'b0);
        tick(v.bmsk, 1'b1, v.typ, v.ab);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(negedge clk);
        // R9: reset state of every slot; R4: support map
        for (int s = 0; s < 8; s++) begin
            read_slot(s, w);
            check("R9 reset slot", w, 64'h0);
        end
        check("R4 support map", {60'h0, log_support}, {60'h0, 4'b1011});
        rst = 1'b0;

        // R1 R2 R3 R4 R5 R6 R7 R8: table walk
        for (int i = 0; i < 9; i++) begin
            run_vec(VECS[i]);
            read_slot(i % 8, w);
            check("R1 R2 R3 R4 R5 R6 record", w,
                  mk(VECS[i].ab, VECS[i].vld, VECS[i].typ, VECS[i].eevt, VECS[i].ecyc));
        end
        // R8: slot 0 overwritten by the ninth record, others intact
        for (int s = 0; s < 8; s++) begin
            int src;
            src = (s == 0) ? 8 : s;
            read_slot(s, w);
            check("R8 ring wrap", w,
                  mk(VECS[src].ab, VECS[src].vld, VECS[src].typ, VECS[src].eevt, VECS[src].ecyc));
        end

        // R9: reset mid-interval discards partial counts and clears slots
        evt_log_en = 4'hF;
        tick(4'h1, 1'b0, 4'd0, 1'b0);
        tick(4'h1, 1'b0, 4'd0, 1'b0);
        rst = 1'b1;
        tick(4'h0, 1'b0, 4'd0, 1'b0);
        tick(4'h0, 1'b0, 4'd0, 1'b0);
        rst = 1'b0;
        read_slot(1, w);
        check("R9 slot cleared", w, 64'h0);
        // R6 R3 R9: first record after reset, pulse in branch cycle
        tick(4'h1, 1'b1, 4'd6, 1'b1);
        read_slot(0, w);
        check("R6 R9 first record", w, mk(1'b1, 1'b0, 4'd6, 8'h01, 16'd1));

        // R5: cycle count saturation; R2 with strobe-cycle pulse on full count
        for (int c = 0; c < 70000; c++) tick((c < 4) ? 4'h8 : 4'h0, 1'b0, 4'd0, 1'b0);
        tick(4'h8, 1'b1, 4'd2, 1'b0);
        read_slot(1, w);
        check("R5 R2 saturate", w, mk(1'b0, 1'b1, 4'd2, 8'hC0, 16'hFFFF));
        // R3: next record starts from zero
        tick(4'h0, 1'b1, 4'd8, 1'b0);
        read_slot(2, w);
        check("R3 R5 restart", w, mk(1'b0, 1'b1, 4'd8, 8'h00, 16'd1));
        // R4: enable low in branch cycle zeroes field
        tick(4'h1, 1'b0, 4'd0, 1'b0);
        evt_log_en = 4'hE;
        tick(4'h1, 1'b1, 4'd3, 1'b0);
        read_slot(3, w);
        check("R4 disabled field", w, mk(1'b0, 1'b1, 4'd3, 8'h00, 16'd2));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule